// File: doc/BRIEF.md
# Quad-Port Word Memory with Write Arbitration

This block is a single-clock memory of 512 words of 18 bits. Two write ports and two read ports can all be used in the same cycle. Each write port carries two lane-enable bits, so the upper or the lower half of a word can be written without disturbing the other half. A mode input selects what happens when both write ports hit the same word in the same cycle. In merge mode the lanes are shared out between the ports. In strict mode port A wins, and a sticky error flag records the clash.

After reset the block fills every word from a computed image, then reports that it is ready. The image is an arithmetic sequence that two parameters define. A small state machine controls the fill. Its states are SWEEP and RUN. Reset enters SWEEP. SWEEP moves to RUN in the cycle that the last address is filled. RUN stays in RUN until the next reset. Reads are registered. A read that targets a word being written in the same cycle returns the word's previous contents.

Top module: `qpr_ram`

## Requirements
- R1: While reset is asserted, `ready`, `coll_err` and both read data outputs are 0. After reset is released, `ready` goes high exactly DEPTH clock edges later and then stays high.
- R2: Once `ready` is high, and before any write, word i holds (INIT_SEED + i*INIT_STEP) truncated to 18 bits.
- R3: The read data of each read port equals the word at the address that port presented one clock edge earlier. The two read ports work independently of each other.
- R4: Lane-enable bit 0 writes bits 8:0 and bit 1 writes bits 17:9. A lane whose enable is 0 keeps its stored value.
- R5: When the two write ports target different addresses, both writes take effect in the same cycle.
- R6: A read of an address that is written in the same cycle returns the data held before that write.
- R7: With `arb_on`=1, a collision is both write ports using the same address with at least one lane enabled each. In a collision, port A's data goes into every lane both ports enable, and a lane enabled by only one port takes that port's data. `coll_err` is not set.
- R8: With `arb_on`=0, in a collision only port A's enabled lanes are written, port B's whole write is discarded, and `coll_err` reads 1 from the next cycle on.
- R9: `coll_err` stays 1 until a cycle with `clr_err`=1 and no strict-mode collision. It reads 0 after that edge. When a strict-mode collision and a clear fall in the same cycle, the flag is set.
- R10: Writes presented while `ready` is low are ignored and never set `coll_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_on | input | 1 | 1 = merge lanes on collision, 0 = strict mode with error flag |
| clr_err | input | 1 | Clears the collision error flag |
| wr_a_addr | input | 9 | Write port A address |
| wr_a_lane | input | 2 | Write port A lane enables |
| wr_a_data | input | 18 | Write port A data |
| wr_b_addr | input | 9 | Write port B address |
| wr_b_lane | input | 2 | Write port B lane enables |
| wr_b_data | input | 18 | Write port B data |
| rd_x_addr | input | 9 | Read port X address |
| rd_x_data | output | 18 | Read port X data, one cycle after the address |
| rd_y_addr | input | 9 | Read port Y address |
| rd_y_data | output | 18 | Read port Y data, one cycle after the address |
| ready | output | 1 | High once the preload fill is complete |
| coll_err | output | 1 | Sticky strict-mode collision flag |

## Verification
Read data and the error flag are both due one clock edge after the inputs that cause them. A write becomes visible to a read issued in the next cycle, never in the same one. The bench drives inputs on the falling edge and records the expected read words and flag value from its own model at that moment. It compares them on the following falling edge, after exactly one rising edge. The ready delay is counted edge by edge from the release of reset.

// File: rtl/qpr_pkg.sv
package qpr_pkg;

    typedef enum logic [0:0] {
        ST_SWEEP = 1'b0,
        ST_RUN   = 1'b1
    } qpr_state_e;

    function automatic logic [31:0] qpr_image_word(
        input logic [31:0] idx,
        input logic [31:0] seed,
        input logic [31:0] step
    );
        return seed + idx * step;
    endfunction

endpackage

// File: rtl/qpr_init_seq.sv
module qpr_init_seq
    import qpr_pkg::*;
#(
    parameter int          DEPTH = 512,
    parameter int          DW    = 18,
    parameter logic [31:0] SEED  = 32'h0000_A5C3,
    parameter logic [31:0] STEP  = 32'h0000_0137,
    localparam int         AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          ready,
    output logic          sw_we,
    output logic [AW-1:0] sw_addr,
    output logic [DW-1:0] sw_data
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    qpr_state_e    state_q, state_d;
    logic [AW-1:0] cnt_q;
    logic [31:0]   word;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SWEEP;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SWEEP: if (cnt_q == LAST) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    // fill address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 cnt_q <= '0;
        else if (state_q == ST_SWEEP && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        ready = 1'b0;
        sw_we = 1'b0;
        unique case (state_q)
            ST_SWEEP: sw_we = 1'b1;
            ST_RUN:   ready = 1'b1;
        endcase
    end

    assign word    = qpr_image_word(32'(cnt_q), SEED, STEP);
    assign sw_addr = cnt_q;
    assign sw_data = word[DW-1:0];

    // R1: once ready, stays ready
    p_ready_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R1: ready rises only after the last address was filled
    p_sweep_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/qpr_arbiter.sv
module qpr_arbiter #(
    parameter int AW    = 9,
    parameter int LANES = 2
) (
    input  logic             ready,
    input  logic             arb_on,
    input  logic [AW-1:0]    a_addr,
    input  logic [LANES-1:0] a_lane,
    input  logic [AW-1:0]    b_addr,
    input  logic [LANES-1:0] b_lane,
    output logic [LANES-1:0] a_eff,
    output logic [LANES-1:0] b_eff,
    output logic             collide
);

    always_comb begin
        collide = ready && (a_addr == b_addr) && (|a_lane) && (|b_lane);
        a_eff   = ready ? a_lane : '0;
        b_eff   = '0;
        if (ready) begin
            if (!collide)    b_eff = b_lane;
            else if (arb_on) b_eff = b_lane & ~a_lane;
            else             b_eff = '0;
        end
    end

endmodule

// File: rtl/qpr_bank.sv
module qpr_bank #(
    parameter int  DEPTH = 512,
    parameter int  LANES = 2,
    parameter int  LW    = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    wa_addr,
    input  logic [LANES-1:0] wa_lane,
    input  logic [DW-1:0]    wa_data,
    input  logic [AW-1:0]    wb_addr,
    input  logic [LANES-1:0] wb_lane,
    input  logic [DW-1:0]    wb_data,
    input  logic [AW-1:0]    rx_addr,
    output logic [DW-1:0]    rx_data,
    input  logic [AW-1:0]    ry_addr,
    output logic [DW-1:0]    ry_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] store [DEPTH];
        logic [LW-1:0] x_q, y_q;

        // port A written last, so it would override B on a shared lane
        always_ff @(posedge clk) begin
            if (wb_lane[g]) store[wb_addr] <= wb_data[g*LW +: LW];
            if (wa_lane[g]) store[wa_addr] <= wa_data[g*LW +: LW];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                x_q <= '0;
                y_q <= '0;
            end else begin
                x_q <= store[rx_addr];
                y_q <= store[ry_addr];
            end
        end

        assign rx_data[g*LW +: LW] = x_q;
        assign ry_data[g*LW +: LW] = y_q;
    end

endmodule

// File: rtl/qpr_ram.sv
module qpr_ram #(
    parameter int          DEPTH     = 512,
    parameter int          LANES     = 2,
    parameter int          LANE_W    = 9,
    parameter logic [31:0] INIT_SEED = 32'h0000_A5C3,
    parameter logic [31:0] INIT_STEP = 32'h0000_0137,
    localparam int         AW        = $clog2(DEPTH),
    localparam int         DW        = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arb_on,
    input  logic             clr_err,
    input  logic [AW-1:0]    wr_a_addr,
    input  logic [LANES-1:0] wr_a_lane,
    input  logic [DW-1:0]    wr_a_data,
    input  logic [AW-1:0]    wr_b_addr,
    input  logic [LANES-1:0] wr_b_lane,
    input  logic [DW-1:0]    wr_b_data,
    input  logic [AW-1:0]    rd_x_addr,
    output logic [DW-1:0]    rd_x_data,
    input  logic [AW-1:0]    rd_y_addr,
    output logic [DW-1:0]    rd_y_data,
    output logic             ready,
    output logic             coll_err
);

    logic             sw_we;
    logic [AW-1:0]    sw_addr;
    logic [DW-1:0]    sw_data;
    logic [LANES-1:0] a_eff, b_eff;
    logic             collide;
    logic [AW-1:0]    bank_a_addr;
    logic [LANES-1:0] bank_a_lane;
    logic [DW-1:0]    bank_a_data;
    logic             err_q;

    qpr_init_seq #(
        .DEPTH (DEPTH),
        .DW    (DW),
        .SEED  (INIT_SEED),
        .STEP  (INIT_STEP)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready   (ready),
        .sw_we   (sw_we),
        .sw_addr (sw_addr),
        .sw_data (sw_data)
    );

    qpr_arbiter #(
        .AW    (AW),
        .LANES (LANES)
    ) u_arb (
        .ready   (ready),
        .arb_on  (arb_on),
        .a_addr  (wr_a_addr),
        .a_lane  (wr_a_lane),
        .b_addr  (wr_b_addr),
        .b_lane  (wr_b_lane),
        .a_eff   (a_eff),
        .b_eff   (b_eff),
        .collide (collide)
    );

    // port A path carries the preload fill until ready
    always_comb begin
        if (ready) begin
            bank_a_addr = wr_a_addr;
            bank_a_lane = a_eff;
            bank_a_data = wr_a_data;
        end else begin
            bank_a_addr = sw_addr;
            bank_a_lane = {LANES{sw_we}};
            bank_a_data = sw_data;
        end
    end

    qpr_bank #(
        .DEPTH (DEPTH),
        .LANES (LANES),
        .LW    (LANE_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_addr (bank_a_addr),
        .wa_lane (bank_a_lane),
        .wa_data (bank_a_data),
        .wb_addr (wr_b_addr),
        .wb_lane (b_eff),
        .wb_data (wr_b_data),
        .rx_addr (rd_x_addr),
        .rx_data (rd_x_data),
        .ry_addr (rd_y_addr),
        .ry_data (rd_y_data)
    );

    // sticky strict-mode collision flag; set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  err_q <= 1'b0;
        else if (collide && !arb_on) err_q <= 1'b1;
        else if (clr_err)            err_q <= 1'b0;
    end

    assign coll_err = err_q;

    // R7: merge mode never writes one lane from both ports
    p_lanes_disjoint_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && arb_on && wr_a_addr == wr_b_addr) |-> ((a_eff & b_eff) == '0));

    // R8: strict-mode collision drops port B and raises the flag
    p_strict_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !arb_on && wr_a_addr == wr_b_addr && |wr_a_lane && |wr_b_lane)
        |-> (b_eff == '0));

    p_err_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (collide && !arb_on) |=> coll_err);

    // R9: flag sticky without clear; clear works without a new collision
    p_err_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_err && !clr_err) |=> coll_err);

    p_err_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !(collide && !arb_on)) |=> !coll_err);

    // R10: no user write reaches the bank before ready
    p_init_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (b_eff == '0 && a_eff == '0 && !collide));

endmodule

// File: tb/sim_qpr_ram.sv
module sim_qpr_ram;

    localparam int          DEPTH = 512;
    localparam int          LANES = 2;
    localparam int          LW    = 9;
    localparam int          DW    = 18;
    localparam int          AW    = 9;
    localparam logic [31:0] SEED  = 32'h0000_A5C3;
    localparam logic [31:0] STEP  = 32'h0000_0137;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arb_on = 1'b1;
    logic          clr_err = 1'b0;
    logic [AW-1:0] wa_addr = '0, wb_addr = '0, rx_addr = '0, ry_addr = '0;
    logic [1:0]    wa_lane = '0, wb_lane = '0;
    logic [DW-1:0] wa_data = '0, wb_data = '0;
    logic [DW-1:0] rx_data, ry_data;
    logic          ready, coll_err;

    always #4 clk = ~clk;

    qpr_ram #(
        .DEPTH     (DEPTH),
        .LANES     (LANES),
        .LANE_W    (LW),
        .INIT_SEED (SEED),
        .INIT_STEP (STEP)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_on    (arb_on),
        .clr_err   (clr_err),
        .wr_a_addr (wa_addr),
        .wr_a_lane (wa_lane),
        .wr_a_data (wa_data),
        .wr_b_addr (wb_addr),
        .wr_b_lane (wb_lane),
        .wr_b_data (wb_data),
        .rd_x_addr (rx_addr),
        .rd_x_data (rx_data),
        .rd_y_addr (ry_addr),
        .rd_y_data (ry_data),
        .ready     (ready),
        .coll_err  (coll_err)
    );

    int            n_tests = 0;
    int            n_fail  = 0;
    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] exp_x, exp_y;
    logic          exp_err = 1'b0;
    bit            have_exp = 1'b0;
    string         cur_tag = "R3";

    function automatic logic [DW-1:0] image(input int i);
        logic [31:0] v;
        v = SEED + 32'(i) * STEP;
        return v[DW-1:0];
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // called at a falling edge: check last step's results, then drive the next
    task automatic step(input logic arb, input logic clr,
                        input logic [AW-1:0] aa, input logic [1:0] al, input logic [DW-1:0] ad,
                        input logic [AW-1:0] ba, input logic [1:0] bl, input logic [DW-1:0] bd,
                        input logic [AW-1:0] xa, input logic [AW-1:0] ya, input string tag);
        bit coll;
        if (have_exp) begin
            chk(cur_tag, "rd_x_data", 32'(rx_data), 32'(exp_x));
            chk(cur_tag, "rd_y_data", 32'(ry_data), 32'(exp_y));
            chk(cur_tag, "coll_err", 32'(coll_err), 32'(exp_err));
        end
        arb_on = arb; clr_err = clr;
        wa_addr = aa; wa_lane = al; wa_data = ad;
        wb_addr = ba; wb_lane = bl; wb_data = bd;
        rx_addr = xa; ry_addr = ya;
        exp_x = model[xa];
        exp_y = model[ya];
        coll = (aa == ba) && (al != 0) && (bl != 0);
        if (!coll || arb) begin
            for (int l = 0; l < LANES; l++)
                if (bl[l]) model[ba][l*LW +: LW] = bd[l*LW +: LW];
        end
        for (int l = 0; l < LANES; l++)
            if (al[l]) model[aa][l*LW +: LW] = ad[l*LW +: LW];
        if (coll && !arb) exp_err = 1'b1;
        else if (clr)     exp_err = 1'b0;
        have_exp = 1'b1;
        cur_tag  = tag;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] xa, input logic [AW-1:0] ya, input string tag);
        step(1'b1, 1'b0, '0, 2'b00, '0, '0, 2'b00, '0, xa, ya, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        for (int i = 0; i < DEPTH; i++) model[i] = image(i);

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "ready in reset", 32'(ready), 0);
        chk("R1", "coll_err in reset", 32'(coll_err), 0);
        chk("R1", "rd_x_data in reset", 32'(rx_data), 0);
        chk("R1", "rd_y_data in reset", 32'(ry_data), 0);

        // R10: colliding strict-mode writes held during the fill
        arb_on = 1'b0;
        wa_addr = 9'd3; wa_lane = 2'b11; wa_data = 18'h00000;
        wb_addr = 9'd3; wb_lane = 2'b11; wb_data = 18'h3FFFF;
        rst_n = 1'b1;
        cyc = 0;
        while (!ready && cyc < DEPTH + 10) begin
            @(posedge clk);
            @(negedge clk);
            cyc++;
        end
        chk("R1", "edges until ready", 32'(cyc), 32'(DEPTH));
        chk("R10", "coll_err after fill", 32'(coll_err), 0);
        wa_lane = 2'b00; wb_lane = 2'b00; arb_on = 1'b1;

        rd(9'd3, 9'd3, "R10");
        // R2: full image readback on both read ports
        for (int i = 0; i < DEPTH; i++) rd(AW'(i), AW'(DEPTH - 1 - i), "R2");
        rd(0, 0, "R1");
        chk("R1", "ready holds", 32'(ready), 1);

        // R5: independent writes on distinct addresses
        step(1'b1, 1'b0, 9'd10, 2'b11, 18'h12345, 9'd20, 2'b11, 18'h2ABCD, 9'd0, 9'd0, "R5");
        rd(9'd10, 9'd20, "R5");

        // R4: single-lane writes
        step(1'b1, 1'b0, 9'd60, 2'b10, 18'h3FFFF, 9'd61, 2'b01, 18'h3FFFF, 9'd0, 9'd0, "R4");
        rd(9'd60, 9'd61, "R4");

        // R6: read during write returns old word, next read new word
        step(1'b1, 1'b0, 9'd70, 2'b11, 18'h0F0F0, 9'd71, 2'b11, 18'h30303, 9'd70, 9'd71, "R6");
        rd(9'd70, 9'd71, "R6");

        // R7: merge mode collisions
        step(1'b1, 1'b0, 9'd50, 2'b01, 18'h11111, 9'd50, 2'b11, 18'h22222, 9'd0, 9'd0, "R7");
        step(1'b1, 1'b0, 9'd51, 2'b11, 18'h01234, 9'd51, 2'b11, 18'h3ABCD, 9'd50, 9'd0, "R7");
        step(1'b1, 1'b0, 9'd52, 2'b10, 18'h1C1C1, 9'd52, 2'b01, 18'h0E0E0, 9'd51, 9'd0, "R7");
        rd(9'd52, 9'd50, "R7");

        // R8: strict mode collision
        step(1'b0, 1'b0, 9'd40, 2'b01, 18'h15555, 9'd40, 2'b11, 18'h2AAAA, 9'd0, 9'd0, "R8");
        rd(9'd40, 9'd40, "R8");

        // R9: sticky, clear, set beats clear
        rd(9'd1, 9'd2, "R9");
        rd(9'd1, 9'd2, "R9");
        step(1'b1, 1'b1, '0, 2'b00, '0, '0, 2'b00, '0, 9'd1, 9'd2, "R9");
        rd(9'd1, 9'd2, "R9");
        step(1'b0, 1'b1, 9'd80, 2'b10, 18'h00AAA, 9'd80, 2'b01, 18'h00555, 9'd80, 9'd0, "R9");
        rd(9'd80, 9'd1, "R9");
        step(1'b1, 1'b1, '0, 2'b00, '0, '0, 2'b00, '0, 9'd1, 9'd2, "R9");
        rd(9'd1, 9'd2, "R9");

        // R3: random traffic with forced collisions and read-during-write hits
        for (int n = 0; n < 4000; n++) begin
            logic          arb;
            logic          clr;
            logic [AW-1:0] aa, ba, xa, ya;
            logic [1:0]    al, bl;
            logic [DW-1:0] ad, bd;
            arb = ((n / 500) % 2) == 0;
            clr = ($urandom % 16) == 0;
            aa  = ($urandom % 2) ? AW'($urandom % 16) : AW'($urandom);
            ba  = ($urandom % 4 == 0) ? aa : (($urandom % 2) ? AW'($urandom % 16) : AW'($urandom));
            al  = 2'($urandom);
            bl  = 2'($urandom);
            ad  = DW'($urandom);
            bd  = DW'($urandom);
            xa  = ($urandom % 3 == 0) ? aa : AW'($urandom % 32);
            ya  = ($urandom % 3 == 0) ? ba : AW'($urandom);
            step(arb, clr, aa, al, ad, ba, bl, bd, xa, ya, "R3");
        end
        rd(0, 0, "R3");
        rd(0, 0, "R3");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule